// File: doc/BRIEF.md
# Flash Erase Suspend and Write-Lock Controller

This block is the command and sequencing core of a block-erasable memory model. Commands arrive as a 3-bit opcode with a block index. They are sampled only when the command strobe and chip enable are both high. Program and erase operations run on a cycle-counting engine that stands in for the cell array. Before an operation starts, a hardware protection check is applied. This check uses decoded pin levels: supply above lockout, reset driven low, reset at high voltage, and write-protect.

An erase runs as a sequence of equal steps. A suspend request does not stop the erase at once. It is honoured at the next step boundary, and the status register then shows the suspended state. While suspended, the block accepts only a small set of commands, and array reads are refused for the block whose erase is paused. Chip enable low during suspension signals standby. A resume continues the erase from the step where it stopped. The status register reports ready, suspension and sticky error flags. A new program or erase is refused until those flags are cleared.

Top module: `flash_susp_ctrl`

## Requirements
- R1: After reset, or for as long as `pin_reset_low` is high, the controller is idle and `status_o` reads 0x80. The status bits are: bit7 ready, bit6 erase suspended, bit5 erase error, bit4 program error, bit3 supply-lockout error, bit1 locked-block error. Bits 2 and 0 read 0.
- R2: Opcodes are 1 read-array, 2 read-status, 3 clear-status, 4 program, 5 erase, 6 suspend, 7 resume. A command is taken only on a cycle with `cmd_valid` and `chip_en` both high.
- R3: An accepted erase holds ready low for STEP_CYC*ERASE_STEPS cycles and sets ready on the last of them. An accepted program does the same over PROG_CYC cycles.
- R4: A suspend during an erase takes effect at the next step boundary. From then on `status_o` reads 0xC0.
- R5: While suspended, program, erase and clear-status are ignored: the status stays 0xC0 and no operation starts.
- R6: In read-array mode, `arr_rd_ok` is high when idle. While suspended, it is high only if `rd_blk` differs from the block being erased.
- R7: While suspended, `standby` is high exactly while `chip_en` is low. A resume issued with `chip_en` low has no effect.
- R8: A resume continues the erase from the next step. Ready rises after the remaining (ERASE_STEPS - steps done)*STEP_CYC cycles.
- R9: With `supply_ok` low, a program or erase fails without starting. It sets bit3 plus bit4 (program) or bit5 (erase). This check takes priority over the block lock.
- R10: The boot block is block 0 (or the last block when BOOT_TOP=1). It is locked when `pin_reset_hv` and `wprot` are both low; an operation on it then sets bit1 plus bit4 or bit5. Either input high unlocks it, and other blocks are never locked.
- R11: Error bits stay set until a clear-status command. While any error bit is set, program and erase are ignored.
- R12: `stat_sel` goes high on read-status or on the start of an operation, and goes low on read-array. It is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command opcode |
| cmd_blk | input | BW | Target block of the command |
| chip_en | input | 1 | Chip enable, active high |
| rd_blk | input | BW | Block addressed by an array read |
| supply_ok | input | 1 | Programming supply above lockout |
| pin_reset_low | input | 1 | Reset pin driven low (holds device in reset) |
| pin_reset_hv | input | 1 | Reset pin at high voltage (unlocks all blocks) |
| wprot | input | 1 | Write-protect level, high unlocks boot block |
| status_o | output | 8 | Status register |
| stat_sel | output | 1 | Reads return status rather than array data |
| arr_rd_ok | output | 1 | Array read permitted for `rd_blk` |
| standby | output | 1 | Suspended and deselected |

## Verification
The bench builds the block with STEP_CYC=4, ERASE_STEPS=3 and PROG_CYC=3, so a full erase lasts twelve cycles and a program three. With these values, a suspend issued mid-step can be checked against the exact boundary cycle. The resume then has a known remainder of eight cycles to count. These short counts also let every protection case in the vector table complete within a fixed wait. The default BOOT_TOP=0 puts the lock on block 0.

// File: rtl/flash_susp_pkg.sv
package flash_susp_pkg;

   typedef enum logic [2:0] {
      OP_NONE    = 3'd0,
      OP_RD_ARR  = 3'd1,
      OP_RD_STAT = 3'd2,
      OP_CLEAR   = 3'd3,
      OP_PROG    = 3'd4,
      OP_ERASE   = 3'd5,
      OP_SUSP    = 3'd6,
      OP_RESUME  = 3'd7
   } fsc_op_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ERASE = 2'd1,
      ST_PROG  = 2'd2,
      ST_SUSP  = 2'd3
   } fsc_state_e;

endpackage

// File: rtl/fsc_protect.sv
module fsc_protect #(
   parameter int N_BLK    = 8,
   parameter bit BOOT_TOP = 1'b0,
   localparam int BW      = $clog2(N_BLK)
) (
   input  logic          supply_ok,
   input  logic          rp_hv,
   input  logic          wprot,
   input  logic [BW-1:0] blk,
   output logic          supply_fail,
   output logic          blk_locked
);

   logic is_boot;

   generate
      if (BOOT_TOP) begin : g_boot_top
         assign is_boot = (blk == BW'(N_BLK - 1));
      end else begin : g_boot_bottom
         assign is_boot = (blk == '0);
      end
   endgenerate

   assign supply_fail = !supply_ok;
   assign blk_locked  = is_boot && !rp_hv && !wprot;

endmodule

// File: rtl/fsc_step_seq.sv
module fsc_step_seq #(
   parameter int STEP_CYC    = 4096,
   parameter int ERASE_STEPS = 16,
   parameter int PROG_CYC    = 64
) (
   input  logic clk,
   input  logic clr,
   input  logic start,
   input  logic run,
   input  logic prog_mode,
   output logic boundary,
   output logic last
);

   localparam int MAXC = (STEP_CYC > PROG_CYC) ? STEP_CYC : PROG_CYC;
   localparam int CW   = $clog2(MAXC);
   localparam int SW   = $clog2(ERASE_STEPS);
   localparam logic [CW-1:0] ELIM  = CW'(STEP_CYC - 1);
   localparam logic [CW-1:0] PLIM  = CW'(PROG_CYC - 1);
   localparam logic [SW-1:0] SLAST = SW'(ERASE_STEPS - 1);

   generate
      if (STEP_CYC < 2 || PROG_CYC < 2 || ERASE_STEPS < 2) begin : g_bad_cfg
         $error("fsc_step_seq: cycle and step counts must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cyc_q;
   logic [SW-1:0] step_q;

   assign boundary = run && (cyc_q == (prog_mode ? PLIM : ELIM));
   assign last     = boundary && (prog_mode || step_q == SLAST);

   always_ff @(posedge clk) begin
      if (clr || start) begin
         cyc_q  <= '0;
         step_q <= '0;
      end else if (run) begin
         if (boundary) begin
            cyc_q <= '0;
            if (!last) step_q <= step_q + 1'b1;
         end else begin
            cyc_q <= cyc_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/flash_susp_ctrl.sv
module flash_susp_ctrl
   import flash_susp_pkg::*;
#(
   parameter int N_BLK       = 8,
   parameter int STEP_CYC    = 4096,
   parameter int ERASE_STEPS = 16,
   parameter int PROG_CYC    = 64,
   parameter bit BOOT_TOP    = 1'b0,
   localparam int BW         = $clog2(N_BLK)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_valid,
   input  logic [2:0]    cmd_op,
   input  logic [BW-1:0] cmd_blk,
   input  logic          chip_en,
   input  logic [BW-1:0] rd_blk,
   input  logic          supply_ok,
   input  logic          pin_reset_low,
   input  logic          pin_reset_hv,
   input  logic          wprot,
   output logic [7:0]    status_o,
   output logic          stat_sel,
   output logic          arr_rd_ok,
   output logic          standby
);

   generate
      if (N_BLK < 2) begin : g_bad_blk
         $error("flash_susp_ctrl: at least two blocks are required");
      end
   endgenerate

   fsc_state_e    state_q;
   fsc_op_e       op;
   logic          rst_all, acc, is_wr, err_any, go_op;
   logic          sup_fail, locked, seq_bnd, seq_last, run, sus_now;
   logic          mode_stat_q, pend_q;
   logic          e_err_q, p_err_q, v_err_q, l_err_q;
   logic [BW-1:0] op_blk_q;

   assign op      = fsc_op_e'(cmd_op);
   assign rst_all = !rst_n || pin_reset_low;
   assign acc     = cmd_valid && chip_en;
   assign is_wr   = (op == OP_PROG) || (op == OP_ERASE);
   assign err_any = e_err_q || p_err_q || v_err_q || l_err_q;
   assign go_op   = (state_q == ST_IDLE) && acc && is_wr && !err_any &&
                    !sup_fail && !locked;
   assign run     = (state_q == ST_ERASE) || (state_q == ST_PROG);
   assign sus_now = acc && (op == OP_SUSP);

   fsc_protect #(.N_BLK(N_BLK), .BOOT_TOP(BOOT_TOP)) u_prot (
      .supply_ok   (supply_ok),
      .rp_hv       (pin_reset_hv),
      .wprot       (wprot),
      .blk         (cmd_blk),
      .supply_fail (sup_fail),
      .blk_locked  (locked)
   );

   fsc_step_seq #(
      .STEP_CYC(STEP_CYC), .ERASE_STEPS(ERASE_STEPS), .PROG_CYC(PROG_CYC)
   ) u_seq (
      .clk       (clk),
      .clr       (rst_all),
      .start     (go_op),
      .run       (run),
      .prog_mode (state_q == ST_PROG),
      .boundary  (seq_bnd),
      .last      (seq_last)
   );

   always_ff @(posedge clk) begin
      if (rst_all) begin
         state_q     <= ST_IDLE;
         mode_stat_q <= 1'b0;
         pend_q      <= 1'b0;
         op_blk_q    <= '0;
         e_err_q     <= 1'b0;
         p_err_q     <= 1'b0;
         v_err_q     <= 1'b0;
         l_err_q     <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (acc) begin
                  case (op)
                     OP_RD_ARR:  mode_stat_q <= 1'b0;
                     OP_RD_STAT: mode_stat_q <= 1'b1;
                     OP_CLEAR: begin
                        e_err_q <= 1'b0;
                        p_err_q <= 1'b0;
                        v_err_q <= 1'b0;
                        l_err_q <= 1'b0;
                     end
                     OP_PROG, OP_ERASE: begin
                        if (!err_any) begin
                           mode_stat_q <= 1'b1;
                           if (sup_fail || locked) begin
                              v_err_q <= sup_fail;
                              l_err_q <= !sup_fail;
                              if (op == OP_ERASE) e_err_q <= 1'b1;
                              else                p_err_q <= 1'b1;
                           end else begin
                              state_q  <= (op == OP_ERASE) ? ST_ERASE : ST_PROG;
                              op_blk_q <= cmd_blk;
                           end
                        end
                     end
                     default: ;
                  endcase
               end
            end
            ST_ERASE: begin
               if (acc && op == OP_RD_STAT) mode_stat_q <= 1'b1;
               if (seq_last) begin
                  state_q <= ST_IDLE;
                  pend_q  <= 1'b0;
               end else if (seq_bnd && (pend_q || sus_now)) begin
                  state_q <= ST_SUSP;
                  pend_q  <= 1'b0;
               end else if (sus_now) begin
                  pend_q <= 1'b1;
               end
            end
            ST_PROG: begin
               if (acc && op == OP_RD_STAT) mode_stat_q <= 1'b1;
               if (seq_last) state_q <= ST_IDLE;
            end
            ST_SUSP: begin
               if (acc) begin
                  case (op)
                     OP_RD_ARR:  mode_stat_q <= 1'b0;
                     OP_RD_STAT: mode_stat_q <= 1'b1;
                     OP_RESUME:  state_q     <= ST_ERASE;
                     default: ;
                  endcase
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign status_o  = {(state_q == ST_IDLE) || (state_q == ST_SUSP),
                       (state_q == ST_SUSP),
                       e_err_q, p_err_q, v_err_q, 1'b0, l_err_q, 1'b0};
   assign stat_sel  = mode_stat_q;
   assign arr_rd_ok = !mode_stat_q &&
                      ((state_q == ST_IDLE) ||
                       ((state_q == ST_SUSP) && (rd_blk != op_blk_q)));
   assign standby   = (state_q == ST_SUSP) && !chip_en;

endmodule

// File: rtl/fsc_checker.sv
module fsc_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       pin_reset_low,
   input logic       cmd_valid,
   input logic [2:0] cmd_op,
   input logic       chip_en,
   input logic [7:0] status_o,
   input logic       standby
);

   logic acc;
   assign acc = cmd_valid && chip_en;

   // R4: suspension is a ready state
   p_susp_ready_r4: assert property (@(posedge clk) disable iff (!rst_n || pin_reset_low)
      status_o[6] |-> status_o[7]);

   // R4: suspension is entered only from a running erase
   p_susp_from_busy_r4: assert property (@(posedge clk) disable iff (!rst_n || pin_reset_low)
      $rose(status_o[6]) |-> !$past(status_o[7]));

   // R5: a program command while suspended keeps the suspension
   p_prog_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n || pin_reset_low)
      (status_o[6] && acc && cmd_op == 3'd4) |=> status_o[6]);

   // R7: standby only while suspended and deselected
   p_standby_r7: assert property (@(posedge clk) disable iff (!rst_n || pin_reset_low)
      standby |-> (status_o[6] && !chip_en));

   // R7: no command leaves suspension while deselected
   p_desel_hold_r7: assert property (@(posedge clk) disable iff (!rst_n || pin_reset_low)
      (status_o[6] && !chip_en) |=> status_o[6]);

   // R11: an erase error stays until a clear command
   p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n || pin_reset_low)
      (status_o[5] && !(acc && cmd_op == 3'd3)) |=> status_o[5]);

   // R1: reserved status bits read zero
   p_reserved_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o[2] == 1'b0) && (status_o[0] == 1'b0));

endmodule

bind flash_susp_ctrl fsc_checker u_chk (.*);

// File: tb/flash_susp_ctrl_tb.sv
`timescale 1ns/1ps
module flash_susp_ctrl_tb;

   localparam int BW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic [2:0]    cmd_op = 3'd0;
   logic [BW-1:0] cmd_blk = '0;
   logic          chip_en = 1'b1;
   logic [BW-1:0] rd_blk = '0;
   logic          supply_ok = 1'b1;
   logic          pin_reset_low = 1'b0;
   logic          pin_reset_hv = 1'b0;
   logic          wprot = 1'b0;
   logic [7:0]    status_o;
   logic          stat_sel, arr_rd_ok, standby;

   int n_chk = 0;
   int n_err = 0;

   always #4 clk = ~clk;

   flash_susp_ctrl #(
      .N_BLK(8), .STEP_CYC(4), .ERASE_STEPS(3), .PROG_CYC(3), .BOOT_TOP(1'b0)
   ) u_dut (.*);

   // vector: op, blk, supply_ok, pin_reset_hv, wprot, expected status
   localparam logic [16:0] VEC [8] = '{
      {3'd5, 3'd3, 1'b1, 1'b0, 1'b0, 8'h80},   // R3 erase ordinary block
      {3'd5, 3'd0, 1'b1, 1'b0, 1'b0, 8'hA2},   // R10 boot locked
      {3'd5, 3'd0, 1'b1, 1'b1, 1'b0, 8'h80},   // R10 hv unlock
      {3'd5, 3'd0, 1'b1, 1'b0, 1'b1, 8'h80},   // R10 wp unlock
      {3'd4, 3'd0, 1'b1, 1'b0, 1'b0, 8'h92},   // R10 program locked
      {3'd4, 3'd5, 1'b0, 1'b0, 1'b0, 8'h98},   // R9 program lockout
      {3'd5, 3'd2, 1'b0, 1'b1, 1'b1, 8'hA8},   // R9 erase lockout
      {3'd4, 3'd0, 1'b0, 1'b0, 1'b0, 8'h98}    // R9 lockout before lock
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic cmd(input logic [2:0] op, input logic [BW-1:0] blk);
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_op    = op;
      cmd_blk   = blk;
      @(negedge clk);
      cmd_valid = 1'b0;
      cmd_op    = 3'd0;
   endtask

   task automatic wait_neg(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      wait_neg(3);
      rst_n = 1'b1;
      wait_neg(1);
      chk("R1 reset status", status_o, 8'h80);
      chk("R12 reset stat_sel", {7'd0, stat_sel}, 8'd0);
      chk("R6 idle array read", {7'd0, arr_rd_ok}, 8'd1);

      for (int v = 0; v < 8; v++) begin
         @(negedge clk);
         supply_ok    = VEC[v][10];
         pin_reset_hv = VEC[v][9];
         wprot        = VEC[v][8];
         cmd(3'd3, '0);
         cmd(VEC[v][16:14], VEC[v][13:11]);
         wait_neg(14);
         chk("R9/R10 vector status", status_o, VEC[v][7:0]);
      end
      supply_ok = 1'b1; pin_reset_hv = 1'b0; wprot = 1'b0;

      // R11: sticky error blocks next operation
      cmd(3'd5, 3'd3);
      wait_neg(2);
      chk("R11 error blocks erase", status_o, 8'h98);
      cmd(3'd3, '0);
      chk("R11 clear", status_o, 8'h80);

      // R12 and R3: erase timing
      cmd(3'd1, '0);
      chk("R12 read-array select", {7'd0, stat_sel}, 8'd0);
      cmd(3'd5, 3'd3);
      chk("R12 status after start", {7'd0, stat_sel}, 8'd1);
      chk("R3 busy", status_o, 8'h00);
      wait_neg(11);
      chk("R3 busy at last cycle", status_o, 8'h00);
      wait_neg(1);
      chk("R3 erase done", status_o, 8'h80);

      // R3 program timing
      cmd(3'd4, 3'd6);
      wait_neg(2);
      chk("R3 program busy", status_o, 8'h00);
      wait_neg(1);
      chk("R3 program done", status_o, 8'h80);

      // R4: suspend at the step boundary
      cmd(3'd5, 3'd3);
      cmd(3'd6, '0);
      wait_neg(1);
      chk("R4 before boundary", status_o, 8'h00);
      wait_neg(1);
      chk("R4 suspended", status_o, 8'hC0);

      // R5: ignored commands while suspended
      cmd(3'd4, 3'd5);
      wait_neg(3);
      chk("R5 program ignored", status_o, 8'hC0);
      cmd(3'd5, 3'd4);
      wait_neg(3);
      chk("R5 erase ignored", status_o, 8'hC0);

      // R6: reads during suspension
      cmd(3'd1, '0);
      rd_blk = 3'd3;
      wait_neg(1);
      chk("R6 suspended block refused", {7'd0, arr_rd_ok}, 8'd0);
      rd_blk = 3'd1;
      wait_neg(1);
      chk("R6 other block allowed", {7'd0, arr_rd_ok}, 8'd1);

      // R7: standby and gated resume
      chip_en = 1'b0;
      wait_neg(1);
      chk("R7 standby", {7'd0, standby}, 8'd1);
      cmd(3'd7, '0);
      wait_neg(1);
      chk("R7 resume ignored deselected", status_o, 8'hC0);
      chip_en = 1'b1;
      wait_neg(1);
      chk("R7 standby off", {7'd0, standby}, 8'd0);

      // R8: resume runs the remaining two steps
      cmd(3'd7, '0);
      chk("R8 resumed busy", status_o, 8'h00);
      wait_neg(7);
      chk("R8 still busy", status_o, 8'h00);
      wait_neg(1);
      chk("R8 completed", status_o, 8'h80);

      // R1: reset pin low aborts an erase
      cmd(3'd5, 3'd2);
      wait_neg(2);
      pin_reset_low = 1'b1;
      wait_neg(1);
      chk("R1 pin reset status", status_o, 8'h80);
      pin_reset_low = 1'b0;
      wait_neg(1);
      chk("R2 no command without valid", status_o, 8'h80);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule